// File: doc/BRIEF.md
# Serial PLL Configuration Sequencer

This block programs a frequency synthesizer once after power-up through a three-wire serial port. The port has a data line, a serial clock and an active-low enable. After reset the block holds the pins idle while the supply and the synthesizer's reference settle. It then sends a reset preamble and writes four words one after the other. The first word ends the reset sequence. The others are a configuration word, a reference-divider word and a feedback-divider word. The synthesizer has no address field: it decides which internal register receives a word from how many bits were clocked in while enable was low. Each word therefore has its own length, and the lengths and values are parameters.

All pin timing is built from one timebase, the slot. A slot lasts `DIV` system cycles, and every pin change happens at a slot boundary. Each bit uses two slots. In the first, data is presented with the clock low. In the second, the clock is high. This gives a full slot of data setup before every rising edge. When the last word has been latched, the block raises `done_o` and holds the pins idle until the next reset.

Top module: `pll_cfg_seq`

## Requirements
- R1: While reset is asserted, and for STARTUP_SLOTS plus SETTLE_SLOTS slots after it is released, the pins are idle: ser_en_n_o=1, ser_clk_o=0, ser_data_o=0. done_o is 0 during this time. A slot is DIV system cycles long, and the outputs of slot k appear after rising clock edge k*DIV counted from reset release.
- R2: The preamble follows. It is PRE_PULSES (default 4) clock pulses with ser_en_n_o held at 1 and ser_data_o held at 0. Each pulse is one slot with the clock low, then one slot with the clock high.
- R3: Every word is framed by the enable line. ser_en_n_o falls one slot before the word's first rising clock edge, and in that slot both clock and data are low. It stays low through one hold slot after the last falling clock edge, in which the data keeps the last bit. It then returns to 1 for one gap slot before the next frame begins.
- R4: Bits go out MSB first. Each bit is one slot with the data presented and the clock low, then one slot with the clock high. Data does not change while the clock is high.
- R5: The words go out in this order: a 5-bit word of value 2, an 8-bit configuration word of value 0, a 15-bit reference-divider word of value 80, and a 16-bit feedback-divider word of value 2140. Each frame holds exactly as many rising clock edges as its length.
- R6: Every high interval of ser_clk_o lasts exactly DIV system cycles.
- R7: done_o rises one slot after the enable rise that ends the last frame. From then on the pins stay idle and done_o stays at 1 until reset.
- R8: An asynchronous reset at any point returns the pins to idle and done_o to 0. After release, the whole sequence restarts from the start-up delay.
- R9: With DIV=1 the prescaler is replaced by a constant strobe. The same slot sequence then runs at one system cycle per slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_o | output | 1 | Serial data to the synthesizer |
| ser_clk_o | output | 1 | Serial clock, idles low |
| ser_en_n_o | output | 1 | Active-low write enable; rising edge latches the word |
| done_o | output | 1 | Set once the last word is latched, held until reset |

## Verification
The bench aims at the places where word length decides the target register. It decodes every frame at the pins and compares both the bit count and the value. An off-by-one in the bit counter would send a 15-bit word as 14 or 16 bits, so the word would land in the wrong register. A reversed bit order would make the decoded values mismatch. A second instance runs with DIV=1 and asymmetric bit patterns. This exposes a broken prescaler bypass, and it exposes data that changes in the same cycle as the rising clock, which would shift every bit by one. A reset in the middle of the sequence, taken after the fast instance has finished, shows whether done is sticky only until reset and whether the sequence really restarts from the start-up delay.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

   localparam int N_WORDS = 4;
   localparam int WSEL_W  = 2;

   typedef enum logic [2:0] {
      ST_START,
      ST_SETTLE,
      ST_PRE,
      ST_LEAD,
      ST_BIT,
      ST_HOLD,
      ST_GAP,
      ST_DONE
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pll_cfg_tick.sv
module pll_cfg_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   generate
      if (DIV == 1) begin : g_bypass
         logic unused_inputs;
         assign unused_inputs = clk ^ rst_n;
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/pll_cfg_words.sv
module pll_cfg_words #(
   parameter int RST_LEN = 5,
   parameter int RST_VAL = 2,
   parameter int CFG_LEN = 8,
   parameter int CFG_VAL = 0,
   parameter int REF_LEN = 15,
   parameter int REF_VAL = 80,
   parameter int FB_LEN  = 16,
   parameter int FB_VAL  = 2140,
   parameter int MAX_W   = 16,
   parameter int IDX_W   = 4
) (
   input  logic [1:0]       len_sel_i,
   output logic [IDX_W-1:0] last_o,
   input  logic [1:0]       bit_sel_i,
   input  logic [IDX_W-1:0] bit_idx_i,
   output logic             bit_o
);

   localparam logic [MAX_W-1:0] V_RST = MAX_W'(RST_VAL);
   localparam logic [MAX_W-1:0] V_CFG = MAX_W'(CFG_VAL);
   localparam logic [MAX_W-1:0] V_REF = MAX_W'(REF_VAL);
   localparam logic [MAX_W-1:0] V_FB  = MAX_W'(FB_VAL);

   always_comb begin
      unique case (len_sel_i)
         2'd0:    last_o = IDX_W'(RST_LEN - 1);
         2'd1:    last_o = IDX_W'(CFG_LEN - 1);
         2'd2:    last_o = IDX_W'(REF_LEN - 1);
         default: last_o = IDX_W'(FB_LEN - 1);
      endcase
   end

   logic [MAX_W-1:0] word_val;

   always_comb begin
      unique case (bit_sel_i)
         2'd0:    word_val = V_RST;
         2'd1:    word_val = V_CFG;
         2'd2:    word_val = V_REF;
         default: word_val = V_FB;
      endcase
      bit_o = word_val[bit_idx_i];
   end

endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
   import pll_cfg_pkg::*;
#(
   parameter int DIV           = 4,
   parameter int STARTUP_SLOTS = 50,
   parameter int SETTLE_SLOTS  = 25,
   parameter int PRE_PULSES    = 4,
   parameter int RST_LEN       = 5,
   parameter int RST_VAL       = 2,
   parameter int CFG_LEN       = 8,
   parameter int CFG_VAL       = 0,
   parameter int REF_LEN       = 15,
   parameter int REF_VAL       = 80,
   parameter int FB_LEN        = 16,
   parameter int FB_VAL        = 2140
) (
   input  logic clk,
   input  logic rst_n,
   output logic ser_data_o,
   output logic ser_clk_o,
   output logic ser_en_n_o,
   output logic done_o
);

   localparam int MAX_W   = max2(max2(RST_LEN, CFG_LEN), max2(REF_LEN, FB_LEN));
   localparam int IDX_W   = (MAX_W > 1) ? $clog2(MAX_W) : 1;
   localparam int SUB_MAX = max2(max2(STARTUP_SLOTS, SETTLE_SLOTS), PRE_PULSES);
   localparam int SUB_W   = $clog2(SUB_MAX + 1);
   localparam logic [SUB_W-1:0] START_LAST  = SUB_W'(STARTUP_SLOTS - 1);
   localparam logic [SUB_W-1:0] SETTLE_LAST = SUB_W'(SETTLE_SLOTS - 1);
   localparam logic [SUB_W-1:0] PRE_LAST    = SUB_W'(PRE_PULSES - 1);
   localparam logic [WSEL_W-1:0] WORD_LAST  = WSEL_W'(N_WORDS - 1);

   // elaboration-time parameter checks
   generate
      if (DIV < 1) begin : g_bad_div
         $error("DIV must be at least 1");
      end
      if (STARTUP_SLOTS < 1 || SETTLE_SLOTS < 1 || PRE_PULSES < 1) begin : g_bad_delay
         $error("delay and preamble counts must be at least 1");
      end
      if (RST_LEN < 1 || CFG_LEN < 1 || REF_LEN < 1 || FB_LEN < 1 || MAX_W > 31) begin : g_bad_len
         $error("word lengths must lie between 1 and 31");
      end
      if ((RST_VAL >> RST_LEN) != 0 || (CFG_VAL >> CFG_LEN) != 0 ||
          (REF_VAL >> REF_LEN) != 0 || (FB_VAL >> FB_LEN) != 0 ||
          RST_VAL < 0 || CFG_VAL < 0 || REF_VAL < 0 || FB_VAL < 0) begin : g_bad_val
         $error("a word value does not fit its length");
      end
   endgenerate

   logic tick;

   pll_cfg_tick #(.DIV(DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   seq_state_t        state_q, state_d;
   logic [SUB_W-1:0]  sub_q,   sub_d;
   logic              phase_q, phase_d;
   logic [IDX_W-1:0]  bit_q,   bit_d;
   logic [WSEL_W-1:0] word_q,  word_d;
   logic [IDX_W-1:0]  last_bit;
   logic              cur_bit;

   pll_cfg_words #(
      .RST_LEN (RST_LEN), .RST_VAL (RST_VAL),
      .CFG_LEN (CFG_LEN), .CFG_VAL (CFG_VAL),
      .REF_LEN (REF_LEN), .REF_VAL (REF_VAL),
      .FB_LEN  (FB_LEN),  .FB_VAL  (FB_VAL),
      .MAX_W   (MAX_W),   .IDX_W   (IDX_W)
   ) u_words (
      .len_sel_i (word_q),
      .last_o    (last_bit),
      .bit_sel_i (word_d),
      .bit_idx_i (bit_d),
      .bit_o     (cur_bit)
   );

   // slot sequencing: every transition happens on a prescaler strobe
   always_comb begin
      state_d = state_q;
      sub_d   = sub_q;
      phase_d = phase_q;
      bit_d   = bit_q;
      word_d  = word_q;
      if (tick) begin
         unique case (state_q)
            ST_START: begin
               if (sub_q == START_LAST) begin
                  state_d = ST_SETTLE;
                  sub_d   = '0;
               end else begin
                  sub_d = sub_q + 1'b1;
               end
            end
            ST_SETTLE: begin
               if (sub_q == SETTLE_LAST) begin
                  state_d = ST_PRE;
                  sub_d   = '0;
                  phase_d = 1'b0;
               end else begin
                  sub_d = sub_q + 1'b1;
               end
            end
            ST_PRE: begin
               phase_d = ~phase_q;
               if (phase_q) begin
                  if (sub_q == PRE_LAST) begin
                     state_d = ST_LEAD;
                     sub_d   = '0;
                     word_d  = '0;
                  end else begin
                     sub_d = sub_q + 1'b1;
                  end
               end
            end
            ST_LEAD: begin
               state_d = ST_BIT;
               bit_d   = last_bit;
               phase_d = 1'b0;
            end
            ST_BIT: begin
               phase_d = ~phase_q;
               if (phase_q) begin
                  if (bit_q == '0) state_d = ST_HOLD;
                  else             bit_d   = bit_q - 1'b1;
               end
            end
            ST_HOLD: state_d = ST_GAP;
            ST_GAP: begin
               if (word_q == WORD_LAST) begin
                  state_d = ST_DONE;
               end else begin
                  word_d  = word_q + 1'b1;
                  state_d = ST_LEAD;
               end
            end
            default: state_d = ST_DONE;
         endcase
      end
   end

   // pin values decoded from the next state so the pins are registered
   logic en_n_d, sclk_d, sdata_d;

   always_comb begin
      en_n_d  = !(state_d inside {ST_LEAD, ST_BIT, ST_HOLD});
      sclk_d  = (state_d inside {ST_PRE, ST_BIT}) && phase_d;
      sdata_d = (state_d inside {ST_BIT, ST_HOLD}) && cur_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_START;
         sub_q      <= '0;
         phase_q    <= 1'b0;
         bit_q      <= '0;
         word_q     <= '0;
         ser_en_n_o <= 1'b1;
         ser_clk_o  <= 1'b0;
         ser_data_o <= 1'b0;
         done_o     <= 1'b0;
      end else begin
         state_q    <= state_d;
         sub_q      <= sub_d;
         phase_q    <= phase_d;
         bit_q      <= bit_d;
         word_q     <= word_d;
         ser_en_n_o <= en_n_d;
         ser_clk_o  <= sclk_d;
         ser_data_o <= sdata_d;
         done_o     <= (state_d == ST_DONE);
      end
   end

endmodule

// File: rtl/pll_cfg_seq_chk.sv
module pll_cfg_seq_chk #(
   parameter int DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic ser_data_o,
   input logic ser_clk_o,
   input logic ser_en_n_o,
   input logic done_o
);

   int hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_run <= 0;
      else if (ser_clk_o) hi_run <= hi_run + 1;
      else                hi_run <= 0;
   end

   a_r4_data_stable_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk_o |-> $stable(ser_data_o));

   a_r3_en_stable_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk_o |-> $stable(ser_en_n_o));

   a_r3_frame_opens_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_en_n_o) |-> (!ser_clk_o && !ser_data_o));

   a_r6_high_len: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_clk_o && hi_run != 0) |-> hi_run == DIV);

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ser_en_n_o && !ser_clk_o && !ser_data_o));

   a_r1_no_done_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_en_n_o |-> !done_o);

endmodule

bind pll_cfg_seq pll_cfg_seq_chk #(.DIV(DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ser_data_o (ser_data_o),
   .ser_clk_o  (ser_clk_o),
   .ser_en_n_o (ser_en_n_o),
   .done_o     (done_o)
);

// File: tb/pll_cfg_seq_tb.sv
`timescale 1ns/1ps
module pll_cfg_seq_tb;

   typedef bit [2:0] slot_q_t[$];

   localparam int D0 = 4,  ST0 = 50, SE0 = 25;
   localparam int D1 = 1,  ST1 = 1,  SE1 = 1;
   localparam int LENS [4] = '{5, 8, 15, 16};
   localparam int VAL0 [4] = '{2, 0, 80, 2140};
   localparam int VAL1 [4] = '{2, 195, 23130, 42435};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic d0, c0, e0, dn0;
   logic d1, c1, e1, dn1;

   pll_cfg_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .ser_data_o(d0), .ser_clk_o(c0), .ser_en_n_o(e0), .done_o(dn0)
   );

   pll_cfg_seq #(
      .DIV(D1), .STARTUP_SLOTS(ST1), .SETTLE_SLOTS(SE1),
      .CFG_VAL(195), .REF_VAL(23130), .FB_VAL(42435)
   ) u_dut_fast (
      .clk(clk), .rst_n(rst_n),
      .ser_data_o(d1), .ser_clk_o(c1), .ser_en_n_o(e1), .done_o(dn1)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   slot_q_t q0, q1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // slot stream: {en_n, clk, data} per slot
   function automatic slot_q_t build(input int idle, input int vals [4]);
      slot_q_t q;
      repeat (idle) q.push_back(3'b100);
      repeat (4) begin
         q.push_back(3'b100);
         q.push_back(3'b110);
      end
      for (int w = 0; w < 4; w++) begin
         q.push_back(3'b000);
         for (int b = LENS[w] - 1; b >= 0; b--) begin
            bit v = bit'((vals[w] >> b) & 1);
            q.push_back({2'b00, v});
            q.push_back({2'b01, v});
         end
         q.push_back({2'b00, bit'(vals[w] & 1)});
         q.push_back(3'b100);
      end
      return q;
   endfunction

   function automatic string tag(input int s, input int idle, input int n);
      if (s < idle)      return "R1";
      if (s < idle + 8)  return "R2";
      if (s < n)         return "R4";
      return "R7";
   endfunction

   task automatic run(input int cycles, input bit full);
      bit pe = 1'b1, pc = 1'b0;
      int pre_cnt = 0, nbits = 0, acc = 0, widx = 0, hr = 0;
      for (int j = 1; j <= cycles; j++) begin
         @(posedge clk);
         #1;
         begin
            int s0 = j / D0;
            int s1 = j / D1;
            bit [2:0] x0 = (s0 < q0.size()) ? q0[s0] : 3'b100;
            bit [2:0] x1 = (s1 < q1.size()) ? q1[s1] : 3'b100;
            chk({e0, c0, d0} == x0, tag(s0, ST0 + SE0, q0.size()), int'({e0, c0, d0}), int'(x0));
            chk(dn0 == (s0 >= q0.size()), "R7 done", int'(dn0), int'(s0 >= q0.size()));
            chk({e1, c1, d1} == x1, {tag(s1, ST1 + SE1, q1.size()), "/R9"}, int'({e1, c1, d1}), int'(x1));
            chk(dn1 == (s1 >= q1.size()), "R9 done", int'(dn1), int'(s1 >= q1.size()));
         end
         // protocol decode of the default instance
         if (pe && !e0) begin
            nbits = 0;
            acc = 0;
            chk(!c0, "R3 enable falls with clock low", int'(c0), 0);
         end
         if (!pc && c0) begin
            if (e0) pre_cnt++;
            else begin
               acc = (acc << 1) | int'(d0);
               nbits++;
            end
         end
         if (c0) hr++;
         else if (pc) begin
            chk(hr == D0, "R6 clock high length", hr, D0);
            hr = 0;
         end
         if (!pe && e0) begin
            if (widx < 4) begin
               chk(nbits == LENS[widx], "R5 frame length", nbits, LENS[widx]);
               chk(acc == VAL0[widx], "R5 frame value", acc, VAL0[widx]);
            end
            widx++;
         end
         pe = e0;
         pc = c0;
      end
      if (full) begin
         chk(widx == 4, "R5 frame count", widx, 4);
         chk(pre_cnt == 4, "R2 preamble pulses", pre_cnt, 4);
      end
   endtask

   initial begin
      q0 = build(ST0 + SE0, VAL0);
      q1 = build(ST1 + SE1, VAL1);
      repeat (3) @(posedge clk);
      #1;
      chk({e0, c0, d0, dn0} == 4'b1000, "R1 reset state", int'({e0, c0, d0, dn0}), 8);
      chk({e1, c1, d1, dn1} == 4'b1000, "R1 reset state fast", int'({e1, c1, d1, dn1}), 8);
      @(negedge clk);
      rst_n = 1'b1;
      run(q0.size() * D0 + 20, 1'b1);

      // R8: reset in the middle of the sequence, then a full rerun
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      run(300, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk({e0, c0, d0, dn0} == 4'b1000, "R8 mid reset idle", int'({e0, c0, d0, dn0}), 8);
      chk(dn1 == 1'b0, "R8 done cleared by reset", int'(dn1), 0);
      @(negedge clk);
      rst_n = 1'b1;
      run(q0.size() * D0 + 20, 1'b1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule